// File: doc/BRIEF.md
# Partitioned SIMD Reduction Unit (Absolute-Difference Sum / Inner Product)

This block takes two 128-bit operands, splits them into lanes of 8, 16 or 32 bits, and reduces the whole vector to one scalar in a single issued operation. The scalar is either the sum of unsigned absolute lane differences, used for block matching, or the sum of signed lane products, used for filter taps. Three register stages separate the issue from the result. A valid strobe travels with each operation, and a new operation may be issued on every clock.

An optional window-slide form moves operand A down by one lane before the reduction. The lowest lane is discarded and a caller-supplied lane value enters at the top. A caller stepping a filter across a sample stream, or a search across candidate offsets, therefore supplies only one new lane per step. Nothing stalls a consumer that samples the result too early, so the caller must respect the fixed latency.

Top module: `simd_reduce_unit`

## Requirements
- R1: `lane_sel_i` selects the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, 2 gives four 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W] of each operand.
- R2: With `op_i`=0 the result is the sum over all lanes of |A(k) − B(k)|, with both lanes read as unsigned. Equal operands give zero, and the sum never exceeds 34 bits.
- R3: With `op_i`=1 the result is the sum over all lanes of A(k)·B(k), with both lanes read as signed two's complement. The exact sum is sign-extended to 48 bits, or wrapped to its low 48 bits when it is wider.
- R4: With `shift_i`=1, operand A is first moved down by one lane: lane 0 is dropped, lane k+1 becomes lane k, and the low W bits of `shift_lane_i` fill the top lane. Operand B is used unchanged.
- R5: An operation issued with `issue_i`=1 at clock edge n shows its result with `valid_o`=1 right after edge n+2, and `valid_o` is high only then.
- R6: Operations issued on consecutive cycles each produce their own correct result on consecutive cycles, with no interference between them.
- R7: While `valid_o` is 0, `result_o` is zero. Synchronous reset clears `valid_o` and `result_o`, and drops every operation in flight.
- R8: `lane_sel_i`=3 behaves exactly as 32-bit lanes.
- R9: Bits of `shift_lane_i` above the selected lane width have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Starts an operation on this edge |
| op_i | input | 1 | 0 = absolute-difference sum, 1 = inner product |
| lane_sel_i | input | 2 | Lane width code (0:8, 1:16, 2 or 3:32) |
| shift_i | input | 1 | Slide operand A by one lane before the reduction |
| shift_lane_i | input | 32 | New top lane for the slide, low W bits used |
| opa_i | input | 128 | Operand A (the sliding window) |
| opb_i | input | 128 | Operand B |
| result_o | output | 48 | Reduced scalar |
| valid_o | output | 1 | Result strobe, three edges after issue |

## Verification
A lane boundary taken from the wrong width code corrupts the next strobed result, exactly two edges after the faulty operation is captured. A group partial sum held from an earlier operation appears in the same way, which is why back-to-back random traffic is compared on every cycle. A window slide that moves by the wrong amount, or that takes bits of the new lane above the selected width, changes only results issued with the slide. Directed slide cases are therefore paired with inputs whose upper bits carry noise. A valid flag that drifts from its data shows as a nonzero result on an idle cycle, or as a strobe one cycle away from the expected one.

// File: rtl/simd_reduce_pkg.sv
package simd_reduce_pkg;

  // lane width codes
  typedef enum logic [1:0] {
    LW8   = 2'd0,
    LW16  = 2'd1,
    LW32  = 2'd2,
    LW32X = 2'd3
  } lane_sel_e;

  // reduction kinds
  typedef enum logic {
    RED_SAD = 1'b0,
    RED_DOT = 1'b1
  } red_op_e;

  // width of one reduction group: the widest lane
  localparam int GROUP_W = 32;

endpackage

// File: rtl/sr_window_shift.sv
module sr_window_shift #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] win_i,
  input  logic [31:0]      lane_i,
  input  logic [1:0]       sel_i,
  input  logic             slide_i,
  output logic [VEC_W-1:0] win_o
);
  import simd_reduce_pkg::*;

  always_comb begin
    win_o = win_i;
    if (slide_i) begin
      case (sel_i)
        LW8:     win_o = {lane_i[7:0],  win_i[VEC_W-1:8]};
        LW16:    win_o = {lane_i[15:0], win_i[VEC_W-1:16]};
        default: win_o = {lane_i[31:0], win_i[VEC_W-1:32]};
      endcase
    end
  end

endmodule

// File: rtl/sr_chunk_reduce.sv
module sr_chunk_reduce #(
  parameter int LW    = 8,
  parameter int CW    = 32,
  parameter int ACC_W = 48
) (
  input  logic [CW-1:0]    a_i,
  input  logic [CW-1:0]    b_i,
  input  logic             dot_i,
  output logic [ACC_W-1:0] sum_o
);
  localparam int NL = CW / LW;

  logic [LW-1:0]          la, lb, diff;
  logic signed [2*LW-1:0] prod;
  logic signed [63:0]     term;

  always_comb begin
    sum_o = '0;
    la    = '0;
    lb    = '0;
    diff  = '0;
    prod  = '0;
    term  = '0;
    for (int k = 0; k < NL; k++) begin
      la   = a_i[k*LW +: LW];
      lb   = b_i[k*LW +: LW];
      diff = (la > lb) ? (la - lb) : (lb - la);
      prod = $signed(la) * $signed(lb);
      if (dot_i) term = 64'(prod);
      else       term = $signed(64'(diff));
      sum_o = sum_o + term[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/sr_group_stage.sv
module sr_group_stage #(
  parameter int VEC_W = 128,
  parameter int ACC_W = 48,
  localparam int NG   = VEC_W / simd_reduce_pkg::GROUP_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      v_i,
  input  logic [VEC_W-1:0]          a_i,
  input  logic [VEC_W-1:0]          b_i,
  input  logic                      dot_i,
  input  logic [1:0]                sel_i,
  output logic                      v_o,
  output logic [NG-1:0][ACC_W-1:0]  grp_o
);
  import simd_reduce_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [2:0][ACC_W-1:0] part;

    for (genvar w = 0; w < 3; w++) begin : g_w
      sr_chunk_reduce #(
        .LW   (8 << w),
        .CW   (GROUP_W),
        .ACC_W(ACC_W)
      ) u_chunk (
        .a_i  (a_i[g*GROUP_W +: GROUP_W]),
        .b_i  (b_i[g*GROUP_W +: GROUP_W]),
        .dot_i(dot_i),
        .sum_o(part[w])
      );
    end

    always_ff @(posedge clk) begin
      if (rst) grp_o[g] <= '0;
      else begin
        case (sel_i)
          LW8:     grp_o[g] <= part[0];
          LW16:    grp_o[g] <= part[1];
          default: grp_o[g] <= part[2];
        endcase
      end
    end
  end

endmodule

// File: rtl/sr_sum_stage.sv
module sr_sum_stage #(
  parameter int NG    = 4,
  parameter int ACC_W = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     v_i,
  input  logic [NG-1:0][ACC_W-1:0] grp_i,
  output logic                     v_o,
  output logic [ACC_W-1:0]         sum_o
);
  logic [ACC_W-1:0] total;

  always_comb begin
    total = '0;
    for (int g = 0; g < NG; g++) total = total + grp_i[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o   <= 1'b0;
      sum_o <= '0;
    end else begin
      v_o   <= v_i;
      sum_o <= v_i ? total : '0;
    end
  end

endmodule

// File: rtl/simd_reduce_unit.sv
module simd_reduce_unit #(
  parameter int VEC_W = 128,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic             op_i,
  input  logic [1:0]       lane_sel_i,
  input  logic             shift_i,
  input  logic [31:0]      shift_lane_i,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  output logic [ACC_W-1:0] result_o,
  output logic             valid_o
);
  import simd_reduce_pkg::*;

  localparam int NG = VEC_W / GROUP_W;

  logic [VEC_W-1:0] win;

  // stage 1: windowed operands
  logic             s1_v, s1_dot;
  logic [1:0]       s1_sel;
  logic [VEC_W-1:0] s1_a, s1_b;

  // stage 2: per-group partial sums
  logic                     s2_v;
  logic [NG-1:0][ACC_W-1:0] s2_grp;

  sr_window_shift #(.VEC_W(VEC_W)) u_shift (
    .win_i  (opa_i),
    .lane_i (shift_lane_i),
    .sel_i  (lane_sel_i),
    .slide_i(shift_i),
    .win_o  (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_dot <= 1'b0;
      s1_sel <= '0;
      s1_a   <= '0;
      s1_b   <= '0;
    end else begin
      s1_v   <= issue_i;
      s1_dot <= op_i;
      s1_sel <= lane_sel_i;
      s1_a   <= win;
      s1_b   <= opb_i;
    end
  end

  sr_group_stage #(.VEC_W(VEC_W), .ACC_W(ACC_W)) u_group (
    .clk  (clk),
    .rst  (rst),
    .v_i  (s1_v),
    .a_i  (s1_a),
    .b_i  (s1_b),
    .dot_i(s1_dot),
    .sel_i(s1_sel),
    .v_o  (s2_v),
    .grp_o(s2_grp)
  );

  sr_sum_stage #(.NG(NG), .ACC_W(ACC_W)) u_sum (
    .clk  (clk),
    .rst  (rst),
    .v_i  (s2_v),
    .grp_i(s2_grp),
    .v_o  (valid_o),
    .sum_o(result_o)
  );

endmodule

// File: rtl/simd_reduce_chk.sv
module simd_reduce_chk #(
  parameter int VEC_W = 128,
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic             op_i,
  input logic [1:0]       lane_sel_i,
  input logic             shift_i,
  input logic [VEC_W-1:0] opa_i,
  input logic [VEC_W-1:0] opb_i,
  input logic [ACC_W-1:0] result_o,
  input logic             valid_o
);
  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst == 2'd3);

  // R5: strobe three edges after issue
  p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
    warm |-> (valid_o == $past(issue_i, 3)));

  // R7: idle output is zero
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (result_o == '0));

  // R2: unsigned difference sums fit in 34 bits
  p_sad_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (warm && valid_o && !$past(op_i, 3)) |-> (result_o[ACC_W-1:34] == '0));

  // R2: identical unslid operands give zero
  p_sad_equal_r2: assert property (@(posedge clk) disable iff (rst)
    (warm && valid_o && $past(!op_i && !shift_i && (opa_i == opb_i), 3))
      |-> (result_o == '0));

  // R3: sixteen signed byte products stay within their range
  p_dot8_range_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && valid_o && $past(op_i && (lane_sel_i == 2'd0), 3))
      |-> (($signed(result_o) <= 262144) && ($signed(result_o) >= -260096)));

endmodule

bind simd_reduce_unit simd_reduce_chk #(.VEC_W(VEC_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue_i   (issue_i),
  .op_i      (op_i),
  .lane_sel_i(lane_sel_i),
  .shift_i   (shift_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .result_o  (result_o),
  .valid_o   (valid_o)
);

// File: tb/sim_simd_reduce_unit.sv
`timescale 1ns/1ps
module sim_simd_reduce_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_i = 1'b0;
  logic         op_i = 1'b0;
  logic [1:0]   lane_sel_i = '0;
  logic         shift_i = 1'b0;
  logic [31:0]  shift_lane_i = '0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic [47:0]  result_o;
  logic         valid_o;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R7";

  always #4 clk = ~clk;

  simd_reduce_unit u0 (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i),
    .lane_sel_i(lane_sel_i), .shift_i(shift_i), .shift_lane_i(shift_lane_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .valid_o(valid_o)
  );

  // behavioural reduction straight from the requirements
  function automatic logic [47:0] ref_calc(bit op, bit [1:0] sel, bit sh,
                                           bit [31:0] lane, bit [127:0] a, bit [127:0] b);
    int lw = (sel == 0) ? 8 : (sel == 1) ? 16 : 32;
    longint m = (longint'(1) << lw) - 1;
    longint acc = 0;
    bit [127:0] aw = a;
    bit [127:0] top;
    if (sh) begin
      top = 128'(lane & 32'(m));
      aw  = (a >> lw) | (top << (128 - lw));
    end
    for (int k = 0; k < 128 / lw; k++) begin
      longint x = longint'(aw >> (k * lw)) & m;
      longint y = longint'(b  >> (k * lw)) & m;
      if (op) begin
        if (x[lw-1]) x = x - (longint'(1) << lw);
        if (y[lw-1]) y = y - (longint'(1) << lw);
        acc = acc + x * y;
      end else begin
        acc = acc + ((x > y) ? x - y : y - x);
      end
    end
    return acc[47:0];
  endfunction

  // three-deep expectation pipeline
  bit          pv[3];
  logic [47:0] pr[3];
  string       pt[3];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        pv[i] <= 1'b0; pr[i] <= '0; pt[i] <= "R7";
      end
    end else begin
      pv[2] <= pv[1]; pr[2] <= pr[1]; pt[2] <= pt[1];
      pv[1] <= pv[0]; pr[1] <= pr[0]; pt[1] <= pt[0];
      pv[0] <= issue_i;
      pr[0] <= issue_i ? ref_calc(op_i, lane_sel_i, shift_i, shift_lane_i, opa_i, opb_i) : '0;
      pt[0] <= cur_tag;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (valid_o !== pv[2] || result_o !== pr[2]) begin
      fails++;
      $display("FAIL %s: valid=%0b result=%h, expected valid=%0b result=%h",
               pt[2], valid_o, result_o, pv[2], pr[2]);
    end
  end

  task automatic drive(bit iss, bit op, bit [1:0] sel, bit sh, bit [31:0] lane,
                       bit [127:0] a, bit [127:0] b, string tag);
    @(negedge clk);
    issue_i = iss; op_i = op; lane_sel_i = sel; shift_i = sh;
    shift_lane_i = lane; opa_i = a; opb_i = b; cur_tag = tag;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  function automatic bit [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    bit [127:0] ramp;
    for (int i = 0; i < 16; i++) ramp[i*8 +: 8] = 8'(i + 1);
    repeat (3) @(negedge clk);
    // R7: reset state at the ports
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      fails++;
      $display("FAIL R7: valid=%0b result=%h, expected 0/0", valid_o, result_o);
    end
    @(negedge clk); rst = 1'b0;
    idle(2, "R7");
    // R2: unsigned differences, both orderings (4080)
    drive(1, 0, 0, 0, 0, {128{1'b1}}, '0, "R2");
    drive(1, 0, 0, 0, 0, '0, {128{1'b1}}, "R2");
    drive(1, 0, 2, 0, 0, rnd128(), rnd128(), "R2");
    // R1: same data under each width code
    drive(1, 0, 0, 0, 0, {8{16'h0100}}, '0, "R1");
    drive(1, 0, 1, 0, 0, {8{16'h0100}}, '0, "R1");
    drive(1, 0, 2, 0, 0, {8{16'h0100}}, '0, "R1");
    drive(1, 1, 1, 0, 0, ramp, ramp, "R1");
    // R3: signed products, wrap to 48 bits
    drive(1, 1, 0, 0, 0, {16{8'h80}}, {16{8'h80}}, "R3");
    drive(1, 1, 1, 0, 0, {8{16'hFFFF}}, {8{16'h0001}}, "R3");
    drive(1, 1, 2, 0, 0, {4{32'h80000000}}, {4{32'h80000000}}, "R3");
    drive(1, 1, 2, 0, 0, {4{32'h7FFFFFFF}}, {4{32'h80000000}}, "R3");
    // R4: window slide at every width
    drive(1, 0, 0, 1, 32'h000000AA, ramp, ramp, "R4");
    drive(1, 1, 1, 1, 32'h00001234, ramp, {8{16'h0001}}, "R4");
    drive(1, 0, 2, 1, 32'hCAFEF00D, ramp, '0, "R4");
    // R8: code 3 equals 32-bit lanes
    drive(1, 1, 3, 0, 0, {4{32'hFFFFFFFE}}, {4{32'h00000003}}, "R8");
    drive(1, 0, 3, 1, 32'h11223344, ramp, rnd128(), "R8");
    // R9: upper bits of the new lane are noise
    drive(1, 0, 0, 1, 32'hDEADBE07, '0, '0, "R9");
    drive(1, 1, 1, 1, 32'hFFFF0002, {8{16'h0001}}, {8{16'h0001}}, "R9");
    // R5: isolated operations with gaps
    drive(1, 1, 0, 0, 0, rnd128(), rnd128(), "R5");
    idle(4, "R5");
    drive(1, 0, 1, 1, $urandom, rnd128(), rnd128(), "R5");
    idle(2, "R5");
    // R6: dense random traffic
    for (int i = 0; i < 400; i++)
      drive(1, 1'($urandom), 2'($urandom), 1'($urandom), $urandom, rnd128(), rnd128(), "R6");
    for (int i = 0; i < 200; i++)
      drive(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), $urandom, rnd128(), rnd128(), "R6");
    // R7: reset drops operations in flight
    drive(1, 0, 0, 0, 0, {128{1'b1}}, '0, "R7");
    @(negedge clk); rst = 1'b1; issue_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(5, "R7");
    finish_run();
  end

endmodule